// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between one bus master and a slave that holds 32-bit words (memory or registers). It watches every request for two alias windows. An access that falls in a window is taken as an operation on one bit of a word in the matching word region. An alias read returns that bit alone, in bit 0 of the read data. An alias write sets or clears that bit by reading the word and writing it back. No other access can reach the slave between that read and that write.

Requests outside both windows go to the slave unchanged, one cycle after the master hands them over. The master port uses a valid/ready request and a one-cycle response pulse. The slave port uses the same protocol. The unit takes one request at a time. The `lock` output shows when a read-modify-write sequence is running.

Each window is 32 MB and covers a 1 MB word region. The alias address is built as `alias_base + byte_offset_of_word * 32 + bit * 4`. The unit inverts this to get the word address back as `region_base + {alias[24:7], 2'b00}` and the bit number as `alias[6:2]`.

Top module: `bitband_unit`

## Requirements
- R1: A read whose address is outside both windows goes to the slave with the same address and with `s_write` low. This includes the words just below and just above each window. The slave read data is returned on `m_rdata` unchanged.
- R2: A write outside both windows goes to the slave with the same address, write data and byte strobes. `s_wstrb[k]` enables byte k, meaning bits 8k+7 down to 8k.
- R3: An access in the window 0x22000000 to 0x23FFFFFF uses word address 0x20000000 + {addr[24:7], 2'b00} and bit number addr[6:2].
- R4: An access in the window 0x42000000 to 0x43FFFFFF uses word address 0x40000000 + {addr[24:7], 2'b00} and bit number addr[6:2].
- R5: An alias read sends one read of the word to the slave. It returns the selected bit in `m_rdata[0]`, and `m_rdata[31:1]` is zero.
- R6: An alias write sends exactly two slave operations. The first is a read of the word. The second is a write of the word with all four strobes set. In the write, the selected bit equals `m_wdata[0]` and every other bit keeps its value from the read. Bits `m_wdata[31:1]` and `m_wstrb` have no effect.
- R7: Address bits [1:0] have no effect on an alias access.
- R8: `lock` is high in every cycle from the cycle after an alias write is accepted up to and including its response cycle. While `lock` is high, `m_ready` is low. A request that waits during this time reaches the slave only after the write-back has completed.
- R9: The slave request starts in the cycle after the master request is accepted. It holds its address, data, strobes and direction until `s_ready` is high.
- R10: Each accepted request gets exactly one `m_resp` pulse, one cycle long. For a write, `m_rdata` is zero during that pulse.
- R11: While reset is asserted, and for two cycles after it is released, `m_ready`, `s_valid`, `m_resp` and `lock` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Unit can accept a request |
| m_write | input | 1 | Request is a write |
| m_addr | input | 32 | Request byte address |
| m_wdata | input | 32 | Write data; for an alias write only bit 0 is used |
| m_wstrb | input | 4 | Byte strobes for pass-through writes |
| m_resp | output | 1 | One-cycle response pulse |
| m_rdata | output | 32 | Read data, valid while `m_resp` is high |
| lock | output | 1 | Read-modify-write sequence in progress |
| s_valid | output | 1 | Slave request valid |
| s_ready | input | 1 | Slave accepts the request |
| s_write | output | 1 | Slave request is a write |
| s_addr | output | 32 | Slave word address |
| s_wdata | output | 32 | Slave write data |
| s_wstrb | output | 4 | Slave byte strobes |
| s_resp | input | 1 | Slave response pulse |
| s_rdata | input | 32 | Slave read data, valid with `s_resp` |

## Verification
The risky overlap is a new master request that arrives while an alias write is still between its read and its write-back. To provoke it, the bench hands over an alias write. In the very next cycle, while `lock` is already high, it presents a plain read of the same word and keeps it valid. The bench then checks three things:
- `m_ready` stays low until the write's response.
- The slave log shows the read arriving only after the write-back.
- The read returns the word with the new bit already merged.

The slave inserts varying ready stalls and response delays, so the overlap is tried with many different sequence lengths.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ISSUE = 3'd1,
    ST_RD_WAIT  = 3'd2,
    ST_WR_ISSUE = 3'd3,
    ST_WR_WAIT  = 3'd4,
    ST_RESP     = 3'd5
  } bb_state_e;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_ARD  = 2'd1,
    OP_AWR  = 2'd2
  } bb_op_e;

endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int REGION_W = 20,
  parameter int NWIN     = 2,
  parameter logic [NWIN-1:0][ADDR_W-1:0] ALIAS_BASE  = '0,
  parameter logic [NWIN-1:0][ADDR_W-1:0] REGION_BASE = '0
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic [ADDR_W-1:0]          word_addr,
  output logic [$clog2(DATA_W)-1:0]  bit_idx
);

  localparam int BIT_W   = $clog2(DATA_W);
  localparam int BIT_LSB = $clog2(DATA_W / 8);
  localparam int WORD_SH = BIT_LSB + BIT_W;
  localparam int ALIAS_W = REGION_W + BIT_W;

  logic [NWIN-1:0]             win_hit;
  logic [NWIN-1:0][ADDR_W-1:0] win_word;

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    logic [ADDR_W-1:0] offset;
    always_comb begin
      offset = '0;
      offset[REGION_W-1:BIT_LSB] = addr[ALIAS_W-1:WORD_SH];
    end
    assign win_hit[gi]  = (addr[ADDR_W-1:ALIAS_W] == ALIAS_BASE[gi][ADDR_W-1:ALIAS_W]);
    assign win_word[gi] = REGION_BASE[gi] + offset;
  end

  always_comb begin
    hit       = 1'b0;
    word_addr = addr;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit       = 1'b1;
        word_addr = win_word[i];
      end
    end
  end

  assign bit_idx = addr[WORD_SH-1:BIT_LSB];

endmodule

// File: rtl/bb_bitop.sv
module bb_bitop #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         word,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic                      new_bit,
  output logic                      bit_val,
  output logic [DATA_W-1:0]         merged
);

  localparam int BIT_W = $clog2(DATA_W);

  for (genvar gb = 0; gb < DATA_W; gb++) begin : g_bit
    assign merged[gb] = (bit_idx == BIT_W'(gb)) ? new_bit : word[gb];
  end

  assign bit_val = word[bit_idx];

endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      m_valid,
  output logic                      m_ready,
  input  logic                      m_write,
  input  logic [ADDR_W-1:0]         m_addr,
  input  logic [DATA_W-1:0]         m_wdata,
  input  logic [DATA_W/8-1:0]       m_wstrb,
  output logic                      m_resp,
  output logic [DATA_W-1:0]         m_rdata,
  output logic                      lock,
  input  logic                      dec_hit,
  input  logic [ADDR_W-1:0]         dec_word,
  input  logic [$clog2(DATA_W)-1:0] dec_bit,
  output logic [$clog2(DATA_W)-1:0] bit_q,
  output logic                      wbit_q,
  input  logic                      bit_val,
  input  logic [DATA_W-1:0]         merged,
  output logic                      s_valid,
  input  logic                      s_ready,
  output logic                      s_write,
  output logic [ADDR_W-1:0]         s_addr,
  output logic [DATA_W-1:0]         s_wdata,
  output logic [DATA_W/8-1:0]       s_wstrb,
  input  logic                      s_resp,
  input  logic [DATA_W-1:0]         s_rdata
);

  localparam int STRB_W = DATA_W / 8;
  localparam int BIT_W  = $clog2(DATA_W);

  bb_state_e             state_q, state_d;
  bb_op_e                op_q, op_d;
  logic [ADDR_W-1:0]     addr_q;
  logic [STRB_W-1:0]     strb_q, strb_d;
  logic [DATA_W-1:0]     data_q, data_d;
  logic                  accept;
  logic                  req_en;
  logic                  data_en;

  assign accept = m_valid & m_ready;
  assign req_en = accept;

  // next state and data selection
  always_comb begin
    state_d = state_q;
    data_en = 1'b0;
    data_d  = data_q;
    op_d    = OP_PASS;
    strb_d  = m_wstrb;
    if (dec_hit) begin
      op_d   = m_write ? OP_AWR : OP_ARD;
      strb_d = '1;
    end
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = (m_write && !dec_hit) ? ST_WR_ISSUE : ST_RD_ISSUE;
          data_en = 1'b1;
          data_d  = m_wdata;
        end
      end
      ST_RD_ISSUE: if (s_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (s_resp) begin
          data_en = 1'b1;
          unique case (op_q)
            OP_AWR: begin
              data_d  = merged;
              state_d = ST_WR_ISSUE;
            end
            OP_ARD: begin
              data_d  = {{(DATA_W-1){1'b0}}, bit_val};
              state_d = ST_RESP;
            end
            default: begin
              data_d  = s_rdata;
              state_d = ST_RESP;
            end
          endcase
        end
      end
      ST_WR_ISSUE: if (s_ready) state_d = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (s_resp) begin
          data_en = 1'b1;
          data_d  = '0;
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PASS;
      addr_q <= '0;
      strb_q <= '0;
      bit_q  <= '0;
      wbit_q <= 1'b0;
    end else if (req_en) begin
      op_q   <= op_d;
      addr_q <= dec_word;
      strb_q <= strb_d;
      bit_q  <= dec_bit;
      wbit_q <= m_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign m_ready = (state_q == ST_IDLE) & rst_n;
  assign m_resp  = (state_q == ST_RESP);
  assign m_rdata = data_q;
  assign lock    = (op_q == OP_AWR) && (state_q != ST_IDLE);
  assign s_valid = (state_q == ST_RD_ISSUE) || (state_q == ST_WR_ISSUE);
  assign s_write = (state_q == ST_WR_ISSUE);
  assign s_addr  = addr_q;
  assign s_wdata = s_write ? data_q : '0;
  assign s_wstrb = strb_q;

  logic unused_bits;
  assign unused_bits = ^{BIT_W'(0)};

endmodule

// File: rtl/bitband_unit.sv
module bitband_unit #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int REGION_W = 20,
  parameter int NWIN     = 2,
  parameter logic [NWIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NWIN-1:0][ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                m_valid,
  output logic                m_ready,
  input  logic                m_write,
  input  logic [ADDR_W-1:0]   m_addr,
  input  logic [DATA_W-1:0]   m_wdata,
  input  logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_resp,
  output logic [DATA_W-1:0]   m_rdata,
  output logic                lock,
  output logic                s_valid,
  input  logic                s_ready,
  output logic                s_write,
  output logic [ADDR_W-1:0]   s_addr,
  output logic [DATA_W-1:0]   s_wdata,
  output logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_resp,
  input  logic [DATA_W-1:0]   s_rdata
);

  localparam int BIT_W = $clog2(DATA_W);

  logic              rst_sync_n;
  logic              dec_hit;
  logic [ADDR_W-1:0] dec_word;
  logic [BIT_W-1:0]  dec_bit;
  logic [BIT_W-1:0]  bit_q;
  logic              wbit_q;
  logic              bit_val;
  logic [DATA_W-1:0] merged;

  bb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bb_decode #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REGION_W    (REGION_W),
    .NWIN        (NWIN),
    .ALIAS_BASE  (ALIAS_BASE),
    .REGION_BASE (REGION_BASE)
  ) u_dec (
    .addr      (m_addr),
    .hit       (dec_hit),
    .word_addr (dec_word),
    .bit_idx   (dec_bit)
  );

  bb_bitop #(.DATA_W(DATA_W)) u_bit (
    .word    (s_rdata),
    .bit_idx (bit_q),
    .new_bit (wbit_q),
    .bit_val (bit_val),
    .merged  (merged)
  );

  bb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_write  (m_write),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .m_wstrb  (m_wstrb),
    .m_resp   (m_resp),
    .m_rdata  (m_rdata),
    .lock     (lock),
    .dec_hit  (dec_hit),
    .dec_word (dec_word),
    .dec_bit  (dec_bit),
    .bit_q    (bit_q),
    .wbit_q   (wbit_q),
    .bit_val  (bit_val),
    .merged   (merged),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_write  (s_write),
    .s_addr   (s_addr),
    .s_wdata  (s_wdata),
    .s_wstrb  (s_wstrb),
    .s_resp   (s_resp),
    .s_rdata  (s_rdata)
  );

endmodule

// File: rtl/bitband_unit_chk.sv
module bitband_unit_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int REGION_W = 20,
  parameter int NWIN     = 2,
  parameter logic [NWIN-1:0][ADDR_W-1:0] ALIAS_BASE = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                m_valid,
  input logic                m_ready,
  input logic                m_write,
  input logic [ADDR_W-1:0]   m_addr,
  input logic                m_resp,
  input logic [DATA_W-1:0]   m_rdata,
  input logic                lock,
  input logic                s_valid,
  input logic                s_ready,
  input logic                s_write,
  input logic [ADDR_W-1:0]   s_addr,
  input logic [DATA_W-1:0]   s_wdata,
  input logic [DATA_W/8-1:0] s_wstrb
);

  localparam int TOP_LSB = REGION_W + $clog2(DATA_W);

  logic in_win;
  logic ck_alias;
  logic ck_write;

  always_comb begin
    in_win = 1'b0;
    for (int i = 0; i < NWIN; i++)
      if (m_addr[ADDR_W-1:TOP_LSB] == ALIAS_BASE[i][ADDR_W-1:TOP_LSB]) in_win = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_alias <= 1'b0;
      ck_write <= 1'b0;
    end else if (m_valid && m_ready) begin
      ck_alias <= in_win;
      ck_write <= m_write;
    end
  end

  p_lock_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !m_ready);

  p_issue_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> s_valid);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_addr) && $stable(s_write)
                               && $stable(s_wdata) && $stable(s_wstrb)));

  p_alias_rd_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_resp && ck_alias && !ck_write) |-> (m_rdata[DATA_W-1:1] == '0));

  p_alias_wr_strb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_write && ck_alias) |-> (s_wstrb == '1));

  p_rmw_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && ck_alias && ck_write) |-> lock);

  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_resp |=> !m_resp);

  p_wr_resp_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_resp && ck_write) |-> (m_rdata == '0));

  p_idle_outputs_r11: assert property (@(posedge clk)
    !rst_n |-> (!s_valid && !m_resp && !lock));

endmodule

bind bitband_unit bitband_unit_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .REGION_W   (REGION_W),
  .NWIN       (NWIN),
  .ALIAS_BASE (ALIAS_BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_write (m_write),
  .m_addr  (m_addr),
  .m_resp  (m_resp),
  .m_rdata (m_rdata),
  .lock    (lock),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_write (s_write),
  .s_addr  (s_addr),
  .s_wdata (s_wdata),
  .s_wstrb (s_wstrb)
);

// File: tb/bitband_unit_tb.sv
module bitband_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        m_valid, m_ready, m_write, m_resp, lock;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_wstrb;
  logic        s_valid, s_ready, s_write, s_resp;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic [3:0]  s_wstrb;

  int n_tests;
  int n_fail;

  bitband_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_resp(m_resp), .m_rdata(m_rdata),
    .lock(lock),
    .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_resp(s_resp), .s_rdata(s_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural slave memory
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  logic [15:0] lfsr;
  logic        pend;
  logic [1:0]  pend_cnt;
  logic [31:0] pend_data;
  int          sl_total;
  logic        log_wr   [16];
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  logic [3:0]  log_strb [16];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr     <= 16'hACE1;
      pend     <= 1'b0;
      pend_cnt <= 2'd0;
      s_resp   <= 1'b0;
      s_ready  <= 1'b0;
      s_rdata  <= 32'h0;
      sl_total <= 0;
    end else begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s_ready <= lfsr[3] | lfsr[0];
      s_resp  <= 1'b0;
      if (pend) begin
        if (pend_cnt == 2'd0) begin
          s_resp  <= 1'b1;
          s_rdata <= pend_data;
          pend    <= 1'b0;
        end else begin
          pend_cnt <= pend_cnt - 2'd1;
        end
      end else if (s_valid && s_ready) begin
        logic [31:0] cur;
        cur = mem_rd(s_addr);
        if (s_write) begin
          for (int k = 0; k < 4; k++)
            if (s_wstrb[k]) cur[8*k +: 8] = s_wdata[8*k +: 8];
          mem[s_addr] = cur;
          pend_data <= 32'hDEAD_BEEF;
        end else begin
          pend_data <= cur;
        end
        log_wr[sl_total[3:0]]   <= s_write;
        log_addr[sl_total[3:0]] <= s_addr;
        log_data[sl_total[3:0]] <= s_wdata;
        log_strb[sl_total[3:0]] <= s_wstrb;
        sl_total <= sl_total + 1;
        pend     <= 1'b1;
        pend_cnt <= lfsr[5:4];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // access results
  logic [31:0] r_data;
  bit          r_issue_ok;
  bit          r_lock_ok;
  int          r_start;

  task automatic do_acc(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] st, input bit expect_lock);
    @(negedge clk);
    m_valid = 1'b1; m_write = wr; m_addr = a; m_wdata = d; m_wstrb = st;
    while (!m_ready) @(negedge clk);
    r_start = sl_total;
    @(negedge clk);
    m_valid = 1'b0;
    r_issue_ok = s_valid;
    r_lock_ok  = 1'b1;
    while (!m_resp) begin
      if ((lock !== expect_lock) || (expect_lock && m_ready)) r_lock_ok = 1'b0;
      @(negedge clk);
    end
    if ((lock !== expect_lock) || (expect_lock && m_ready)) r_lock_ok = 1'b0;
    r_data = m_rdata;
    @(negedge clk);
    if (m_resp) r_lock_ok = 1'b0;
  endtask

  function automatic logic [31:0] alias_of(input int win, input logic [31:0] woff, input int b);
    logic [31:0] ab;
    ab = (win == 0) ? 32'h2200_0000 : 32'h4200_0000;
    return ab + woff * 32 + 32'(b) * 4;
  endfunction

  function automatic logic [31:0] word_of(input int win, input logic [31:0] woff);
    return ((win == 0) ? 32'h2000_0000 : 32'h4000_0000) + woff;
  endfunction

  // alias read plus alias write of one bit, both checked
  task automatic bit_case(input int win, input logic [31:0] woff, input int b,
                          input logic [1:0] low, input logic v);
    logic [31:0] w, a, old, exp;
    string tag;
    tag = (win == 0) ? "R3" : "R4";
    w = word_of(win, woff);
    a = alias_of(win, woff, b) | {30'h0, low};
    old = mem_rd(w);
    do_acc(1'b0, a, 32'hFFFF_FFFF, 4'h0, 1'b0);
    chk(r_data == {31'h0, old[b]}, $sformatf("R5 %s R7 alias read bit %0d", tag, b), r_data, {31'h0, old[b]});
    chk((sl_total == r_start + 1) && !log_wr[r_start[3:0]] && log_addr[r_start[3:0]] == w,
        $sformatf("%s alias read word address", tag), log_addr[r_start[3:0]], w);
    chk(r_issue_ok, "R9 issue next cycle", 32'(r_issue_ok), 32'h1);
    exp = old;
    exp[b] = v;
    do_acc(1'b1, a, {lfsr, lfsr[14:0], v}, 4'h0, 1'b1);
    chk(mem_rd(w) == exp, $sformatf("R6 %s alias write bit %0d", tag, b), mem_rd(w), exp);
    chk((sl_total == r_start + 2) && !log_wr[r_start[3:0]] && log_wr[4'(r_start + 1)]
        && log_addr[4'(r_start + 1)] == w && log_strb[4'(r_start + 1)] == 4'hF,
        "R6 read then full-strobe write", 32'(sl_total - r_start), 32'h2);
    chk(r_lock_ok && r_data == 32'h0, "R8 R10 lock window and write response", r_data, 32'h0);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    m_valid = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = '0; m_wstrb = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!m_ready && !s_valid && !m_resp && !lock, "R11 reset outputs",
        {m_ready, s_valid, m_resp, lock}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_ready, "R11 ready held after release", 32'(m_ready), 32'h0);
    repeat (3) @(negedge clk);
    chk(m_ready, "R11 ready after sync", 32'(m_ready), 32'h1);

    // bit sweep over both windows, several words, all bits
    for (int win = 0; win < 2; win++) begin
      for (int wi = 0; wi < 4; wi++) begin
        logic [31:0] woff;
        case (wi)
          0: woff = 32'h0;
          1: woff = 32'h4;
          2: woff = 32'h1_2340;
          default: woff = 32'hF_FFFC;
        endcase
        for (int b = 0; b < 32; b++)
          bit_case(win, woff, b, 2'(b), 1'((b + wi + win) % 3 == 0));
      end
    end

    // pass-through reads at window edges and elsewhere
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, exp;
      case (i)
        0: a = 32'h21FF_FFFC;
        1: a = 32'h2400_0000;
        2: a = 32'h41FF_FFFC;
        3: a = 32'h4400_0000;
        4: a = 32'h2000_0010;
        default: a = 32'h0000_0100;
      endcase
      exp = mem_rd(a);
      do_acc(1'b0, a, 32'h0, 4'h0, 1'b0);
      chk(r_data == exp, "R1 pass read data", r_data, exp);
      chk(sl_total == r_start + 1 && log_addr[r_start[3:0]] == a && !log_wr[r_start[3:0]],
          "R1 pass read address", log_addr[r_start[3:0]], a);
      chk(r_issue_ok, "R9 pass issue next cycle", 32'(r_issue_ok), 32'h1);
    end

    // pass-through writes, every strobe pattern
    for (int st = 0; st < 16; st++) begin
      logic [31:0] a, d, exp;
      a = 32'h4000_0100 + 32'(st) * 4;
      d = 32'hC0DE_0000 ^ (32'(st) * 32'h0101_0101);
      exp = mem_rd(a);
      for (int k = 0; k < 4; k++) if (st[k]) exp[8*k +: 8] = d[8*k +: 8];
      do_acc(1'b1, a, d, 4'(st), 1'b0);
      chk(mem_rd(a) == exp, "R2 pass write merge", mem_rd(a), exp);
      chk(log_strb[r_start[3:0]] == 4'(st) && log_data[r_start[3:0]] == d && log_addr[r_start[3:0]] == a,
          "R2 pass write fields", log_data[r_start[3:0]], d);
      chk(r_data == 32'h0, "R10 write response data", r_data, 32'h0);
    end

    // overlap: read of the same word presented while alias write is locked
    for (int rep = 0; rep < 8; rep++) begin
      logic [31:0] w, a, exp;
      int b, first;
      bit held_ok;
      b = (rep * 5) % 32;
      w = word_of(rep % 2, 32'h80 + 32'(rep) * 4);
      a = alias_of(rep % 2, 32'h80 + 32'(rep) * 4, b);
      exp = mem_rd(w);
      exp[b] = ~exp[b];
      @(negedge clk);
      m_valid = 1'b1; m_write = 1'b1; m_addr = a; m_wdata = {31'h0, exp[b]}; m_wstrb = 4'h0;
      while (!m_ready) @(negedge clk);
      first = sl_total;
      @(negedge clk);
      m_write = 1'b0; m_addr = w; m_wdata = 32'h0;
      held_ok = 1'b1;
      while (!m_resp) begin
        if (m_ready || !lock) held_ok = 1'b0;
        @(negedge clk);
      end
      if (m_ready) held_ok = 1'b0;
      @(negedge clk);
      chk(held_ok, "R8 request held off while locked", 32'(held_ok), 32'h1);
      while (!m_ready) @(negedge clk);
      @(negedge clk);
      m_valid = 1'b0;
      while (!m_resp) @(negedge clk);
      chk(m_rdata == exp, "R8 waiting read sees merged word", m_rdata, exp);
      chk(log_wr[4'(first + 1)] && !log_wr[4'(first + 2)] && sl_total == first + 3,
          "R8 slave order read-write-read", 32'(sl_total - first), 32'h3);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule